// File: doc/BRIEF.md
# Programmable Decimating FIR Filter

A streaming low-pass decimator. The down-sampling factor is chosen at run time, from one to eight. Signed 8-bit samples enter through a valid/ready handshake. After each group of `factor` accepted samples the block forms a weighted sum over a window of `8 × factor` past samples. It rounds and clamps the sum to 8 bits and presents it as a one-cycle output pulse.

Two full coefficient sets are supplied as flat buses, and one select bit picks between them. The window is placed symmetrically around the middle of a 64-entry history. Because of this, every factor sees the same group delay, and a change of rate or coefficient set does not shift the output in time. The tap sum is computed serially with one multiplier, and input is stalled while that sum runs.

Top module: `decim_fir`

## Requirements
- R1: `ratio_i` (3-bit unsigned r) selects decimation factor F = r+1; exactly one output is produced per F accepted input beats.
- R2: The sum uses L = 8·F taps. Tap j (0 ≤ j < L) multiplies the sample accepted d = 32 − 4·F + j beats before the newest one (d = 0 is the newest) by coefficient j. Coefficient j occupies bits [10·j+9 : 10·j] of the selected bank bus.
- R3: `bank_sel_i` = 0 selects `coef_a_i`, 1 selects `coef_b_i`. Coefficients are 10-bit two's complement with 9 fractional bits.
- R4: `ratio_i` and `bank_sel_i` are captured only on the first accepted beat of a period. Changes at any other time take effect for the next period only.
- R5: The full-precision sum S (units of 2^-9) is rounded to nearest with halves toward +∞: y = floor((S + 256) / 512).
- R6: The rounded value is clamped to the range −128..127.
- R7: `in_ready_o` is low for exactly L+1 cycles after the beat that completes a period, and no input is taken in that time.
- R8: `out_valid_o` is high for exactly one cycle, the last of those L+1 cycles, with `out_data_o` valid in that cycle.
- R9: Reset clears the 64-sample history to zero and restarts the period count. During reset `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can take a sample |
| in_data_i | input | 8 | Signed input sample |
| ratio_i | input | 3 | Decimation factor minus one |
| bank_sel_i | input | 1 | Coefficient bank select |
| coef_a_i | input | 640 | Bank A, 64 × 10-bit coefficients |
| coef_b_i | input | 640 | Bank B, 64 × 10-bit coefficients |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 8 | Signed rounded, clamped output |

## Verification
The hardest case to reach is a change of ratio or bank in the middle of a period. In that case the new value must be ignored until the next period starts, while the window length and centring still follow the value that was captured. The stimulus moves `ratio_i` and `bank_sel_i` between individual beats at varied positions within periods. A reference history and the captured settings in the bench predict every sum. Separate runs use saturating coefficient sets and a single half-weight tap on odd samples, which drive the clamp and the half-up rounding directly.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_MAC     = 2'd1,
    ST_OUT     = 2'd2
  } dec_state_e;
endpackage

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_pkg::*;
#(
  parameter int TPP  = 8,
  parameter int MAXF = 8,
  localparam int RW    = $clog2(MAXF),
  localparam int FW    = RW + 1,
  localparam int DEPTH = TPP * MAXF,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [RW-1:0] ratio_i,
  input  logic          bank_i,
  output logic          in_ready_o,
  output logic          shift_o,
  output logic [FW-1:0] fac_o,
  output logic          bank_o,
  output logic          mac_en_o,
  output logic          mac_clr_o,
  output logic [AW-1:0] tap_idx_o,
  output logic          out_valid_o
);
  dec_state_e    state_q;
  logic [FW-1:0] cnt_q, fac_q, fac_eff;
  logic          bank_q;
  logic [AW-1:0] idx_q;
  logic [AW:0]   taps;

  assign in_ready_o = (state_q == ST_COLLECT);
  assign shift_o    = in_valid_i & in_ready_o;
  // settings for the beat that opens a period come straight from the pins
  assign fac_eff    = (cnt_q == '0) ? FW'(ratio_i) + FW'(1) : fac_q;
  assign taps       = (AW+1)'(fac_q) * (AW+1)'(TPP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
      fac_q   <= FW'(1);
      bank_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_COLLECT: if (shift_o) begin
          if (cnt_q == '0) begin
            fac_q  <= FW'(ratio_i) + FW'(1);
            bank_q <= bank_i;
          end
          if (cnt_q + FW'(1) == fac_eff) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= ST_MAC;
          end else begin
            cnt_q <= cnt_q + FW'(1);
          end
        end
        ST_MAC: begin
          idx_q <= idx_q + AW'(1);
          if ({1'b0, idx_q} == taps - (AW+1)'(1)) state_q <= ST_OUT;
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assign fac_o       = fac_q;
  assign bank_o      = bank_q;
  assign mac_en_o    = (state_q == ST_MAC);
  assign mac_clr_o   = (idx_q == '0);
  assign tap_idx_o   = idx_q;
  assign out_valid_o = (state_q == ST_OUT);

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  p_busy_no_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_en_o || out_valid_o) |-> !in_ready_o);
  p_fac_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && $past(cnt_q) != '0) |-> ($stable(fac_q) && $stable(bank_q)));
  p_idx_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_en_o |-> ({1'b0, idx_q} < taps));
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q < fac_q));
endmodule

// File: rtl/dec_delay_line.sv
module dec_delay_line #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] din_i,
  input  logic [AW-1:0]        rd_idx_i,
  output logic signed [DW-1:0] dout_o
);
  logic signed [DW-1:0] line_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic signed [DW-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = din_i;
    end else begin : g_body
      assign nxt = line_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      line_q[g] <= '0;
      else if (shift_i) line_q[g] <= nxt;
    end
  end

  assign dout_o = line_q[rd_idx_i];

  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> ($stable(line_q[0]) && $stable(line_q[DEPTH-1])));
endmodule

// File: rtl/dec_mac.sv
module dec_mac #(
  parameter int DW    = 8,
  parameter int CW    = 10,
  parameter int ACC_W = 25
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 clr_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [CW-1:0] c_i,
  output logic signed [DW-1:0] y_o
);
  localparam int PW   = DW + CW;
  localparam int FRAC = CW - 1;
  localparam int OMAX = 2 ** (DW - 1) - 1;
  localparam int OMIN = -(2 ** (DW - 1));

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] acc_q, acc_base;
  logic signed [ACC_W:0]   rnd, shr;

  assign prod     = x_i * c_i;
  assign acc_base = clr_i ? '0 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_base + {{(ACC_W-PW){prod[PW-1]}}, prod};
  end

  // half-up rounding, then clamp
  assign rnd = {acc_q[ACC_W-1], acc_q} + (ACC_W+1)'(1 << (FRAC - 1));
  assign shr = rnd >>> FRAC;

  always_comb begin
    if (shr > OMAX)      y_o = DW'(OMAX);
    else if (shr < OMIN) y_o = DW'(OMIN);
    else                 y_o = shr[DW-1:0];
  end

  p_acc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(y_o));
endmodule

// File: rtl/decim_fir.sv
module decim_fir #(
  parameter int DW    = 8,
  parameter int CW    = 10,
  parameter int TPP   = 8,
  parameter int MAXF  = 8,
  localparam int RW    = $clog2(MAXF),
  localparam int FW    = RW + 1,
  localparam int DEPTH = TPP * MAXF,
  localparam int AW    = $clog2(DEPTH),
  localparam int ACC_W = DW + CW + AW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [DW-1:0]        in_data_i,
  input  logic [RW-1:0]        ratio_i,
  input  logic                 bank_sel_i,
  input  logic [DEPTH*CW-1:0]  coef_a_i,
  input  logic [DEPTH*CW-1:0]  coef_b_i,
  output logic                 out_valid_o,
  output logic [DW-1:0]        out_data_o
);
  logic          shift, bank, mac_en, mac_clr;
  logic [FW-1:0] fac;
  logic [AW-1:0] tap_idx, rd_idx;
  logic [AW:0]   win_len;
  logic signed [DW-1:0] smp;
  logic signed [CW-1:0] coef;

  dec_ctrl #(.TPP(TPP), .MAXF(MAXF)) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i,
    .ratio_i, .bank_i(bank_sel_i),
    .in_ready_o, .shift_o(shift), .fac_o(fac), .bank_o(bank),
    .mac_en_o(mac_en), .mac_clr_o(mac_clr), .tap_idx_o(tap_idx),
    .out_valid_o
  );

  // window centred on the middle of the history
  assign win_len = (AW+1)'(fac) * (AW+1)'(TPP);
  assign rd_idx  = AW'((AW+1)'(DEPTH / 2) - (win_len >> 1) + (AW+1)'(tap_idx));
  assign coef    = bank ? coef_b_i[tap_idx*CW +: CW] : coef_a_i[tap_idx*CW +: CW];

  dec_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_line (
    .clk_i, .rst_ni, .shift_i(shift), .din_i(in_data_i),
    .rd_idx_i(rd_idx), .dout_o(smp)
  );

  dec_mac #(.DW(DW), .CW(CW), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni, .en_i(mac_en), .clr_i(mac_clr),
    .x_i(smp), .c_i(coef), .y_o(out_data_o)
  );
endmodule

// File: tb/decim_fir_tb.sv
module decim_fir_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [7:0]   in_data_i = '0;
  logic [2:0]   ratio_i = '0;
  logic         bank_sel_i = 1'b0;
  logic [639:0] coef_a_i = '0;
  logic [639:0] coef_b_i = '0;
  logic         out_valid_o;
  logic [7:0]   out_data_o;

  int total = 0, bad = 0;
  string cur_req = "R9";
  int hist [64];
  int m_cnt = 0, m_fac = 1, m_bank = 0;
  int exp_q [$];

  always #2 clk_i = ~clk_i;

  decim_fir u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int cval(input int b, input int j);
    logic signed [9:0] v;
    v = b ? coef_b_i[j*10 +: 10] : coef_a_i[j*10 +: 10];
    return int'(v);
  endfunction

  task automatic model_accept(input int x, output bit last, output int len);
    int acc, y, base;
    if (m_cnt == 0) begin m_fac = int'(ratio_i) + 1; m_bank = int'(bank_sel_i); end
    for (int i = 63; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    m_cnt++;
    last = 0; len = 0;
    if (m_cnt == m_fac) begin
      len = 8 * m_fac; base = 32 - 4 * m_fac; acc = 0;
      for (int j = 0; j < len; j++) acc += hist[base + j] * cval(m_bank, j);
      y = (acc + 256) >>> 9;
      if (y > 127) y = 127;
      if (y < -128) y = -128;
      exp_q.push_back(y);
      m_cnt = 0; last = 1;
    end
  endtask

  task automatic send(input int x);
    bit last; int len, rdy_bad, vld_bad;
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = 8'(x);
    while (!in_ready_o) @(negedge clk_i);
    model_accept(x, last, len);
    @(posedge clk_i); #1;
    if (last) begin
      rdy_bad = 0; vld_bad = 0;
      for (int k = 1; k <= len + 1; k++) begin
        @(negedge clk_i);
        in_valid_i = 1'b0;
        if (in_ready_o) rdy_bad++;
        if (out_valid_o != (k == len + 1)) vld_bad++;
      end
      chk(rdy_bad == 0, "R7 ready low L+1 cycles", rdy_bad, 0);
      chk(vld_bad == 0, "R8 single valid pulse", vld_bad, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; in_valid_i = 1'b0;
    foreach (hist[i]) hist[i] = 0;
    m_cnt = 0;
    repeat (2) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R9 valid low in reset", int'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R9 ready high in reset", int'(in_ready_o), 1);
    rst_ni = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (exp_q.size() == 0) chk(0, {cur_req, " unexpected output"}, int'($signed(out_data_o)), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'($signed(out_data_o)) == e, cur_req, int'($signed(out_data_o)), e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (hist[i]) hist[i] = 0;
    for (int j = 0; j < 64; j++) begin
      coef_a_i[j*10 +: 10] = 10'(j * 7 - 200);
      coef_b_i[j*10 +: 10] = 10'(150 - j * 5);
    end
    do_reset();

    // R9: first period after reset reads a zeroed history
    cur_req = "R9"; ratio_i = 3'd7;
    for (int i = 0; i < 8; i++) send(100 - 13 * i);

    // R1 / R2: sweep every ratio on bank A
    cur_req = "R1R2";
    for (int r = 0; r < 8; r++) begin
      ratio_i = 3'(r);
      for (int i = 0; i < 2 * (r + 1); i++) send(int'($urandom_range(0, 255)) - 128);
    end

    // R3: alternate banks per period
    cur_req = "R3";
    ratio_i = 3'd3;
    for (int p = 0; p < 4; p++) begin
      bank_sel_i = p[0];
      for (int i = 0; i < 4; i++) send(int'($urandom_range(0, 255)) - 128);
    end

    // R4: change ratio and bank inside periods
    cur_req = "R4";
    for (int p = 0; p < 10; p++) begin
      ratio_i = 3'(p % 8); bank_sel_i = p[0];
      for (int i = 0; i < 5; i++) begin
        send(int'($urandom_range(0, 255)) - 128);
        ratio_i = 3'($urandom_range(0, 7));
        bank_sel_i = $urandom_range(0, 1) == 1;
      end
    end
    while (m_cnt != 0) send(17);

    // R6: clamp high and low
    cur_req = "R6";
    for (int j = 0; j < 64; j++) coef_a_i[j*10 +: 10] = 10'(511);
    bank_sel_i = 1'b0; ratio_i = 3'd7;
    for (int i = 0; i < 64; i++) send(127);
    for (int i = 0; i < 64; i++) send(-128);

    // R5: one half-weight tap at delay 28 (F = 1), odd samples
    cur_req = "R5";
    coef_a_i = '0; coef_a_i[9:0] = 10'(256);
    ratio_i = 3'd0;
    for (int i = 0; i < 40; i++) send((i % 2) ? 3 : -3);
    for (int i = 0; i < 30; i++) send(2 * i - 31);

    // R9: reset in the middle of a period
    ratio_i = 3'd7;
    for (int i = 0; i < 3; i++) send(55);
    do_reset();
    cur_req = "R9";
    for (int j = 0; j < 64; j++) coef_a_i[j*10 +: 10] = 10'(j + 1);
    for (int i = 0; i < 16; i++) send(90);

    repeat (5) @(negedge clk_i);
    chk(exp_q.size() == 0, "R8 all outputs seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule